// File: doc/BRIEF.md
# Asynchronous Machine Check Gate

This block turns an external machine-check request, which may change at any moment and bears no relation to the local clock, into a registered, active-low machine-check signal for the local processor. The request is brought into the clock domain through a chain of synchronizing flip-flops (two by default). It is then treated purely as a level. There is no edge detector and no sticky bit, so the output follows the synchronized request and keeps no record of earlier levels.

Two qualifiers gate the output. A configuration enable bit must be set. An internal error-pending level must also be low. While an earlier internal error is still uncleared, the request is simply not looked at. A request that comes and goes inside that window is lost. A request that is still high when software clears the pending error is picked up on the next edge. Mask and status storage for the request, error detection and the processor interrupt logic all sit outside this block.

Top module: `mcg_top`

## Requirements
- R1: While rst_n is low at a rising edge, mc_out_n is high (deasserted) after that edge and the synchronizer stages are cleared, so a request high during reset cannot reach the output until two edges after reset release.
- R2: With SYNC_STAGES=2, a change of mc_req_async sampled at rising edge k shows on mc_out_n after edge k+2, when enable is high and no error is pending (three register stages in total).
- R3: mc_out_n is high after any rising edge at which mc_enable was sampled low (0 = output disabled, 1 = enabled).
- R4: mc_out_n is low after a rising edge exactly when the synchronized request was high, mc_enable was high and err_pending was low at that edge. It stays low for as long as those hold.
- R5: mc_out_n is high after any rising edge at which err_pending was sampled high, whatever the request level.
- R6: A request that rises and falls entirely while err_pending is high never drives mc_out_n low, even after err_pending is cleared.
- R7: If the synchronized request is still high when err_pending falls, mc_out_n goes low after the first rising edge at which err_pending is sampled low.
- R8: There is no edge detection. A request held high continuously reasserts the output when enable returns or a pending error clears, with no new rising edge needed. When the request falls, the output deasserts on the same fixed delay as R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_req_async | input | 1 | External machine-check request, asynchronous, active high |
| err_pending | input | 1 | High while an earlier internal error is uncleared |
| mc_enable | input | 1 | Configuration enable for the output, 1 = enabled |
| mc_out_n | output | 1 | Registered machine-check output, active low |

## Verification
A request change is due at the output after the third rising edge that follows it, counting the two synchronizer flops and the output flop. A change of mc_enable or err_pending is due after the very next edge. The bench drives every input at the falling edge and compares mc_out_n at the next falling edge against a reference that applies those delays. So each comparison lands half a cycle after the edge where the result becomes due. The directed lost-request and still-high cases add checks that count output assertions across a whole window, rather than comparing a single cycle.

// File: rtl/mcg_pkg.sv
// Package: shared constants for the machine-check gate.
// Assumes: nothing; holds only defaults used by the modules.
package mcg_pkg;
    // Default number of synchronizer flops on the asynchronous request.
    localparam int unsigned MCG_SYNC_DEFAULT = 2;
    // Reset value of the active-low output (deasserted).
    localparam logic MCG_OUT_IDLE = 1'b1;
endpackage

// File: rtl/mcg_sync.sv
// Module: mcg_sync
// Brings an asynchronous single-bit level into the clk domain through a
// chain of STAGES flip-flops.
// Assumes: STAGES >= 2; rst_n is synchronous and active low.
module mcg_sync #(
    parameter int unsigned STAGES = mcg_pkg::MCG_SYNC_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // First stage: capture the raw asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_in;
    end

    // Remaining stages: shift the level one flop per edge.
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end

            // R2: each stage carries the previous stage's value one edge later.
            p_shift_r2 : assert property (@(posedge clk) disable iff (!rst_n)
                chain_q[g] == $past(chain_q[g-1]));
        end
    endgenerate

    assign sync_out = chain_q[LAST];

    // R1: reset empties the chain.
    p_sync_clear_r1 : assert property (@(posedge clk)
        !rst_n |=> (chain_q == '0));
endmodule

// File: rtl/mcg_gate.sv
// Module: mcg_gate
// Qualifies the synchronized request with the enable bit and the
// error-pending level and drives the registered active-low output.
// Assumes: req_sync is already in the clk domain; err_pending is a level
// held from error detection until software clears it.
module mcg_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    input  logic err_pending,
    input  logic enable,
    output logic out_n
);
    logic sampled;

    // Sampling window: the request is looked at only with no error pending.
    always_comb sampled = req_sync && !err_pending;

    // Output flop: level-following, no memory of earlier request levels.
    always_ff @(posedge clk) begin
        if (!rst_n) out_n <= mcg_pkg::MCG_OUT_IDLE;
        else        out_n <= !(sampled && enable);
    end

    // R1: output idles high after a reset edge.
    p_reset_idle_r1 : assert property (@(posedge clk)
        !rst_n |=> out_n);
    // R3: a disabled output never asserts.
    p_enable_gates_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> out_n);
    // R5: a pending error blocks sampling.
    p_pending_blocks_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        err_pending |=> out_n);
    // R4: qualified request asserts the output on the next edge.
    p_level_follow_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (req_sync && enable && !err_pending) |=> !out_n);
    // R8: no stored state; a low synchronized request deasserts at once.
    p_no_memory_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        !req_sync |=> out_n);
    // R7: clearing the pending error with the request high asserts next edge.
    p_clear_pickup_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(err_pending) && req_sync && enable) |=> !out_n);
endmodule

// File: rtl/mcg_top.sv
// Module: mcg_top
// Machine-check gate: synchronizes an asynchronous request and drives a
// registered active-low output, gated by an enable bit and blocked while
// an internal error is pending.
// Assumes: err_pending and mc_enable are synchronous to clk.
module mcg_top #(
    parameter int unsigned SYNC_STAGES = mcg_pkg::MCG_SYNC_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_req_async,
    input  logic err_pending,
    input  logic mc_enable,
    output logic mc_out_n
);
    logic req_sync;

    // Request synchronizer.
    mcg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mc_req_async),
        .sync_out (req_sync)
    );

    // Qualification and output register.
    mcg_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_sync    (req_sync),
        .err_pending (err_pending),
        .enable      (mc_enable),
        .out_n       (mc_out_n)
    );

    // R5: output and pending error are never active together one edge apart.
    p_top_pending_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_pending) |-> mc_out_n);
endmodule

// File: tb/mcg_top_test.sv
// Bench: mcg_top_test
// Drives inputs at the falling edge, compares mc_out_n at the next falling
// edge against a reference built from the requirement timings.
module mcg_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic pend = 1'b0;
    logic en = 1'b0;
    logic mc_out_n;

    int n_chk = 0;
    int n_bad = 0;

    // Reference: request delayed two edges, qualifiers one edge (R2, R4).
    logic m1 = 1'b0, m2 = 1'b0, mexp = 1'b1;

    always #4 clk = ~clk; // 125 MHz

    mcg_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mc_req_async (req),
        .err_pending  (pend),
        .mc_enable    (en),
        .mc_out_n     (mc_out_n)
    );

    function automatic logic expect_out(input logic rq2, input logic p, input logic e);
        return !(rq2 && !p && e);
    endfunction

    // Reference model update.
    always @(posedge clk) begin
        if (!rst_n) begin
            m1 <= 1'b0; m2 <= 1'b0; mexp <= 1'b1;
        end else begin
            m1 <= req; m2 <= m1; mexp <= expect_out(m2, pend, en);
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: mc_out_n=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: compare the due result, then apply the next inputs.
    task automatic step(input logic r, input logic p, input logic e, input string tag);
        @(negedge clk);
        chk(tag, mc_out_n, mexp);
        req = r; pend = p; en = e;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not end");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lows;
        void'($urandom(32'h5eed_1234));
        // R1: request and enable high during reset; output idle.
        req = 1'b1; en = 1'b1;
        repeat (4) step(1'b1, 1'b0, 1'b1, "R1");
        @(negedge clk); rst_n = 1'b1;
        chk("R1", mc_out_n, 1'b1);
        // R1/R2: after release, two edges before output can move.
        @(negedge clk); chk("R1", mc_out_n, 1'b1);
        @(negedge clk); chk("R2", mc_out_n, 1'b1);
        @(negedge clk); chk("R2", mc_out_n, 1'b0);
        // R2: falling request, three edges to deassert.
        req = 1'b0;
        step(1'b0, 1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, 1'b1, "R2");
        @(negedge clk); chk("R2", mc_out_n, 1'b1);
        // R3/R8: enable toggled under a held request.
        repeat (4) step(1'b1, 1'b0, 1'b1, "R4");
        repeat (3) step(1'b1, 1'b0, 1'b0, "R3");
        repeat (3) step(1'b1, 1'b0, 1'b1, "R8");
        // R6: short request entirely inside a pending window is lost.
        repeat (3) step(1'b0, 1'b0, 1'b1, "R4");
        lows = 0;
        step(1'b0, 1'b1, 1'b1, "R5");
        repeat (3) step(1'b1, 1'b1, 1'b1, "R5");
        repeat (4) step(1'b0, 1'b1, 1'b1, "R5");
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b0, 1'b1, "R6");
            if (mc_out_n == 1'b0) lows++;
        end
        n_chk++;
        if (lows != 0) begin
            n_bad++;
            $display("FAIL R6: lost request asserted %0d cycles, expected 0", lows);
        end
        // R7: request still high when pending clears.
        step(1'b1, 1'b1, 1'b1, "R5");
        repeat (4) step(1'b1, 1'b1, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b1, "R5");
        @(negedge clk); chk("R7", mc_out_n, 1'b0);
        repeat (2) step(1'b1, 1'b0, 1'b1, "R8");
        // Random mix of held runs (R4, R5, R3).
        for (int i = 0; i < 3000; i++) begin
            logic r, p, e;
            r = ($urandom % 4) != 0 ? req : ~req;
            p = ($urandom % 8) == 0 ? ~pend : pend;
            e = ($urandom % 10) == 0 ? ~en : en;
            step(r, p, e, "R4");
        end
        // R1: reset mid-run returns the output to idle.
        @(negedge clk); rst_n = 1'b0; req = 1'b1; pend = 1'b0; en = 1'b1;
        @(negedge clk); chk("R1", mc_out_n, 1'b1);
        @(negedge clk); chk("R1", mc_out_n, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule